// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus-side fetch engine and an instruction consumer. The fetch engine reads code bytes from a 20-bit linear address, which the block forms from a 16-bit code segment and a 16-bit fetch offset. It pushes each returned byte into a six-byte queue. Only this block advances the fetch offset, by one for every byte it accepts. While the consumer works on one instruction, the producer keeps filling the queue for the next one. Whichever side runs ahead stalls through its handshake.

The consumer takes whole instructions of 1 to 6 bytes. It presents the length it needs, and the request is granted only when at least that many bytes are queued. The queued bytes are always visible on a parallel output, oldest byte in the lowest lane, so the consumer can look at them before it commits to a length. A control transfer asserts `flush` with a new segment and offset. The queue then empties in one cycle and fetching resumes from the new address. A byte presented in the flush cycle is refused.

Both data interfaces are valid/ready. A byte moves only in a cycle where `push_valid` and `push_ready` are both high, and an instruction is removed only where `pop_valid` and `pop_ready` are both high. `push_ready` depends only on the stored level and on `flush`: a full queue refuses a byte even in a cycle that pops. `pop_ready` may be read combinationally from `pop_len`. The producer may hold `push_valid` and the consumer may hold `pop_valid` for any number of cycles without loss.

Top module: `ifq_prefetch_queue`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `level` is 0, `push_ready` is 1, `pop_ready` is 0 and `fetch_addr` equals 0xFFFF0 (segment 0xFFFF, offset 0x0000).
- R2: `level` never exceeds 6. When `level` is 6, `push_ready` is 0 and a presented byte is not accepted.
- R3: When `flush` is low and `level` is below 6, `push_ready` is 1. A byte with `push_valid` high in such a cycle is appended as the newest queued byte.
- R4: `pop_ready` is 1 exactly when `flush` is low, `pop_len` is legal (see R9) and `level` is at least `pop_len`. A cycle with `pop_valid` and `pop_ready` high removes the `pop_len` oldest bytes.
- R5: Lane i of `pop_bytes` (bits 8i+7 down to 8i, i = 0..5) carries the i-th oldest queued byte when i < `level`, and is zero otherwise.
- R6: In a cycle that both accepts a byte and grants a pop, `level` changes by one minus `pop_len`.
- R7: A cycle with `flush` high leaves `level` at 0 on the next cycle, sets the fetch segment and offset to `flush_seg` and `flush_off`, refuses any presented byte and grants no pop.
- R8: `fetch_addr` equals segment × 16 + offset modulo 2^20. The offset increases by one per accepted byte and wraps from 0xFFFF to 0x0000 without changing the segment. With no accepted byte and no flush, `fetch_addr` holds its value.
- R9: A `pop_len` of 0 or of 7 is illegal. It is never granted and does not change `level` or the queued bytes.
- R10: A consumer stall (`pop_valid` high, `pop_ready` low) removes no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Control transfer: empty the queue and reload segment and offset |
| flush_seg | input | 16 | New code segment, loaded with `flush` |
| flush_off | input | 16 | New fetch offset, loaded with `flush` |
| fetch_addr | output | 20 | Linear address of the next byte to fetch |
| push_valid | input | 1 | Fetch side offers a byte |
| push_ready | output | 1 | Queue accepts the offered byte |
| push_byte | input | 8 | Offered code byte |
| pop_valid | input | 1 | Consumer requests an instruction |
| pop_len | input | 3 | Requested instruction length, 1 to 6 |
| pop_ready | output | 1 | Request can be granted this cycle |
| pop_bytes | output | 48 | Queued bytes, oldest in lane 0, unused lanes zero |
| level | output | 3 | Number of queued bytes |

## Verification
On every cycle, the assertions check the occupancy bound and that a full queue refuses bytes. They also check that a flush leaves an empty queue, that a granted length is always legal, that a consumer stall leaves the level alone, and how the segment, offset and address step or hold. Byte order is a different matter. The lane contents after mixed pushes and multi-byte pops, the zeroing of unused lanes, the offset wrap seen at the address and the refusal of a byte offered during a flush all depend on data history. Only the bench can show them, by comparing the ports with its own queue model, both in directed corner cases and across long random runs.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int PARA_SH = 4;
  localparam int ADDR_W  = SEG_W + PARA_SH;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [ADDR_W-1:0] lin_addr_t;

  function automatic lin_addr_t lin_addr(input seg_t s, input off_t o);
    return {s, {PARA_SH{1'b0}}} + lin_addr_t'(o);
  endfunction
endpackage

// File: rtl/ifq_fetch_ptr.sv
module ifq_fetch_ptr
  import ifq_pkg::*;
#(
  parameter seg_t RST_SEG = 16'hFFFF,
  parameter off_t RST_OFF = 16'h0000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  seg_t      flush_seg,
  input  off_t      flush_off,
  input  logic      step,
  output lin_addr_t addr
);
  seg_t seg_q;
  off_t off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (flush) begin
      seg_q <= flush_seg;
      off_q <= flush_off;
    end else if (step) begin
      off_q <= off_q + off_t'(1);
    end
  end

  assign addr = lin_addr(seg_q, off_q);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flush) |=> (off_q == $past(off_q) + off_t'(1))); // R8
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(seg_q)); // R8
endmodule

// File: rtl/ifq_occupancy.sv
module ifq_occupancy #(
  parameter int DEPTH   = 6,
  parameter int MAX_LEN = 6,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_valid,
  input  logic             pop_valid,
  input  logic [LEN_W-1:0] pop_len,
  output logic             push_ready,
  output logic             pop_ready,
  output logic             push_fire,
  output logic             pop_fire,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] level_q;
  logic             len_ok;
  logic             enough;

  assign len_ok     = (pop_len != '0) && (int'(pop_len) <= MAX_LEN);
  assign enough     = int'(level_q) >= int'(pop_len);
  assign push_ready = !flush && (int'(level_q) < DEPTH);
  assign pop_ready  = !flush && len_ok && enough;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (flush) begin
      level_q <= '0;
    end else begin
      level_q <= LVL_W'(int'(level_q) + (push_fire ? 1 : 0)
                        - (pop_fire ? int'(pop_len) : 0));
    end
  end

  assign level = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_q) <= DEPTH); // R2
  AST_STALL_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready && !push_fire && !flush) |=> $stable(level_q)); // R10
endmodule

// File: rtl/ifq_ring.sv
module ifq_ring #(
  parameter int DEPTH   = 6,
  parameter int LANES   = 6,
  parameter int DW      = 8,
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int LEN_W  = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic [LEN_W-1:0]    rd_len,
  input  logic [LVL_W-1:0]    level,
  output logic [LANES*DW-1:0] lanes
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   wr_sum, rd_sum;
  logic [PW-1:0] wr_nxt, rd_nxt;

  assign wr_sum = {1'b0, wr_ptr} + (PW+1)'(1);
  assign rd_sum = {1'b0, rd_ptr} + (PW+1)'(rd_len);
  assign wr_nxt = (wr_sum >= (PW+1)'(DEPTH)) ? PW'(wr_sum - (PW+1)'(DEPTH)) : wr_sum[PW-1:0];
  assign rd_nxt = (rd_sum >= (PW+1)'(DEPTH)) ? PW'(rd_sum - (PW+1)'(DEPTH)) : rd_sum[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en && !flush) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PW:0]   raw;
    logic [PW-1:0] idx;
    assign raw = {1'b0, rd_ptr} + (PW+1)'(i);
    assign idx = (raw >= (PW+1)'(DEPTH)) ? PW'(raw - (PW+1)'(DEPTH)) : raw[PW-1:0];
    assign lanes[i*DW +: DW] = (LVL_W'(i) < level) ? mem[idx] : '0;
  end
endmodule

// File: rtl/ifq_prefetch_queue.sv
module ifq_prefetch_queue
  import ifq_pkg::*;
#(
  parameter int   DEPTH   = 6,
  parameter int   MAX_LEN = 6,
  parameter int   DW      = 8,
  parameter seg_t RST_SEG = 16'hFFFF,
  parameter off_t RST_OFF = 16'h0000,
  localparam int  LVL_W   = $clog2(DEPTH + 1),
  localparam int  LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [15:0]           flush_seg,
  input  logic [15:0]           flush_off,
  output logic [19:0]           fetch_addr,
  input  logic                  push_valid,
  output logic                  push_ready,
  input  logic [DW-1:0]         push_byte,
  input  logic                  pop_valid,
  input  logic [LEN_W-1:0]      pop_len,
  output logic                  pop_ready,
  output logic [MAX_LEN*DW-1:0] pop_bytes,
  output logic [LVL_W-1:0]      level
);
  logic push_fire, pop_fire;

  ifq_occupancy #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_valid(push_valid), .pop_valid(pop_valid), .pop_len(pop_len),
    .push_ready(push_ready), .pop_ready(pop_ready),
    .push_fire(push_fire), .pop_fire(pop_fire), .level(level)
  );

  ifq_ring #(.DEPTH(DEPTH), .LANES(MAX_LEN), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(push_fire), .wr_data(push_byte),
    .rd_en(pop_fire), .rd_len(pop_len),
    .level(level), .lanes(pop_bytes)
  );

  ifq_fetch_ptr #(.RST_SEG(RST_SEG), .RST_OFF(RST_OFF)) u_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .flush_seg(flush_seg), .flush_off(flush_off),
    .step(push_fire), .addr(fetch_addr)
  );

  AST_FULL_STALLS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == DEPTH) |-> !push_ready); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !pop_ready)); // R7
  AST_POP_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready |-> (pop_len != '0 && int'(pop_len) <= MAX_LEN)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_fire && !flush) |=> $stable(fetch_addr)); // R8
endmodule

// File: tb/ifq_prefetch_queue_tb.sv
`timescale 1ns/1ps
module ifq_prefetch_queue_tb;
  localparam int DEPTH = 6;
  localparam int MAXL  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0, flush_off = '0;
  logic [19:0] fetch_addr;
  logic        push_valid = 1'b0, push_ready;
  logic [7:0]  push_byte = '0;
  logic        pop_valid = 1'b0, pop_ready;
  logic [2:0]  pop_len = 3'd1;
  logic [47:0] pop_bytes;
  logic [2:0]  level;

  int tests = 0;
  int fails = 0;

  logic [7:0]  mq[$];
  logic [15:0] mseg = 16'hFFFF, moff = 16'h0000;
  string       lvl_tag = "R1";

  always #2.5 clk = ~clk;

  ifq_prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
    .flush_off(flush_off), .fetch_addr(fetch_addr), .push_valid(push_valid),
    .push_ready(push_ready), .push_byte(push_byte), .pop_valid(pop_valid),
    .pop_len(pop_len), .pop_ready(pop_ready), .pop_bytes(pop_bytes), .level(level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [47:0] exp_lanes();
    logic [47:0] v = '0;
    for (int i = 0; i < MAXL; i++)
      if (i < mq.size()) v[i*8 +: 8] = mq[i];
    return v;
  endfunction

  task automatic cycle(input bit pv, input logic [7:0] pb, input bit qv,
                       input logic [2:0] ql, input bit fl,
                       input logic [15:0] fs, input logic [15:0] fo);
    bit    epr, eqr;
    string ptag, qtag;
    @(negedge clk);
    push_valid = pv; push_byte = pb; pop_valid = qv; pop_len = ql;
    flush = fl; flush_seg = fs; flush_off = fo;
    #1;
    epr = !fl && (mq.size() < DEPTH);
    eqr = !fl && (ql >= 1) && (ql <= MAXL) && (mq.size() >= int'(ql));
    ptag = fl ? "R7" : ((mq.size() == DEPTH) ? "R2" : "R3");
    qtag = fl ? "R7" : ((ql == 0 || ql > MAXL) ? "R9" : "R4");
    chk(level == 3'(mq.size()), lvl_tag, "level", 64'(level), 64'(mq.size()));
    chk(push_ready == epr, ptag, "push_ready", 64'(push_ready), 64'(epr));
    chk(pop_ready == eqr, qtag, "pop_ready", 64'(pop_ready), 64'(eqr));
    chk(pop_bytes == exp_lanes(), "R5", "pop_bytes", 64'(pop_bytes), 64'(exp_lanes()));
    chk(fetch_addr == exp_addr(mseg, moff), lvl_tag == "R7" ? "R7" : "R8",
        "fetch_addr", 64'(fetch_addr), 64'(exp_addr(mseg, moff)));
    if (fl) begin
      mq.delete(); mseg = fs; moff = fo; lvl_tag = "R7";
    end else begin
      if (qv && eqr) for (int k = 0; k < int'(ql); k++) void'(mq.pop_front());
      if (pv && epr) begin mq.push_back(pb); moff = moff + 16'd1; end
      if (qv && eqr && pv && epr) lvl_tag = "R6";
      else if (qv && !eqr) lvl_tag = (ql == 0 || ql > MAXL) ? "R9" : "R10";
      else lvl_tag = "R4";
    end
  endtask

  task automatic idle();
    cycle(1'b0, 8'h00, 1'b0, 3'd1, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(level == 0, "R1", "reset level", 64'(level), 0);
    chk(push_ready == 1'b1, "R1", "reset push_ready", 64'(push_ready), 1);
    chk(pop_ready == 1'b0, "R1", "reset pop_ready", 64'(pop_ready), 0);
    chk(fetch_addr == 20'hFFFF0, "R1", "reset fetch_addr", 64'(fetch_addr), 64'h FFFF0);
    rst_n = 1'b1;
    lvl_tag = "R1";
    idle();

    // R7 redirect, then R3/R2 fill to full, push while full
    cycle(1'b0, 8'h00, 1'b0, 3'd1, 1'b1, 16'h2340, 16'h0018);
    for (int i = 0; i < 7; i++) cycle(1'b1, 8'hA0 + 8'(i), 1'b0, 3'd1, 1'b0, 0, 0);
    idle();
    // R9 illegal lengths while full
    cycle(1'b0, 8'h00, 1'b1, 3'd0, 1'b0, 0, 0);
    cycle(1'b0, 8'h00, 1'b1, 3'd7, 1'b0, 0, 0);
    idle();
    // R4/R2 pop 4 from full with push offered (refused)
    cycle(1'b1, 8'h55, 1'b1, 3'd4, 1'b0, 0, 0);
    idle();
    // R10 stall: ask 3 with 2 present
    cycle(1'b0, 8'h00, 1'b1, 3'd3, 1'b0, 0, 0);
    idle();
    // R6 push with pop of 2
    cycle(1'b1, 8'h66, 1'b1, 3'd2, 1'b0, 0, 0);
    idle();
    // R7 flush with both sides active
    cycle(1'b1, 8'h77, 1'b1, 3'd1, 1'b1, 16'h0100, 16'hFFFE);
    // R8 offset wrap
    for (int i = 0; i < 3; i++) cycle(1'b1, 8'hC0 + 8'(i), 1'b0, 3'd1, 1'b0, 0, 0);
    idle();
    // R5 a full six-byte instruction
    for (int i = 0; i < 3; i++) cycle(1'b1, 8'hD0 + 8'(i), 1'b0, 3'd1, 1'b0, 0, 0);
    cycle(1'b0, 8'h00, 1'b1, 3'd6, 1'b0, 0, 0);
    idle();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit pv, qv, fl;
      logic [2:0] ql;
      logic [15:0] fo;
      pv = ($urandom % 10) < 7;
      qv = ($urandom % 10) < 6;
      fl = ($urandom % 50) == 0;
      ql = (($urandom % 20) == 0) ? 3'(($urandom % 2) * 7) : 3'(1 + $urandom % 6);
      fo = (($urandom % 3) == 0) ? 16'hFFFC + 16'($urandom % 4) : 16'($urandom);
      cycle(pv, 8'($urandom), qv, ql, fl, 16'($urandom), fo);
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule